// File: doc/BRIEF.md
# Bidirectional FIFO Port Access Decoder

This block sits on one side of a pair of FIFOs that share a single bidirectional data bus. One FIFO takes words in from the bus and the other hands words out to it. The block turns the port's control pins (a chip select, a write/read direction select, an operation enable and a mailbox select) into three things. The first is a write strobe for the inbound FIFO. The second is a read strobe for the outbound FIFO. The third is an output-enable for the bus's tri-state drivers.

The output-enable depends only on chip select and direction, and it follows them without waiting for a clock. Strobes come from the rising port clock, so they are registered. An operation also needs the enable to be high, the mailbox select to be low, and the right flag to say there is room for a write or data for a read. The word on the bus is captured at the edge where a write is accepted, and that registered copy goes to the inbound FIFO with the write strobe. The FIFO storage, the mailbox registers and the flag logic live elsewhere. The port pays no attention to what other ports are doing.

Top module: `fifo_port_access`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` is 0 and `dir_wr` is 0. It follows those two inputs with no clock, regardless of `rst`, `op_en`, `mbx_sel` and the flags.
- R2: While `rst` is 1 at a rising edge, `push_stb` and `pop_stb` are 0 and `push_data` is cleared to 0 after that edge.
- R3: At a rising edge where `cs_n`=0, `dir_wr`=1, `op_en`=1, `mbx_sel`=0 and `room_ok`=1 (and `rst`=0), `push_stb` is 1 for the one clock cycle that follows.
- R4: At a rising edge where `cs_n`=0, `dir_wr`=0, `op_en`=1, `mbx_sel`=0 and `data_ok`=1 (and `rst`=0), `pop_stb` is 1 for the one clock cycle that follows.
- R5: When `op_en` is 0 at an edge, neither strobe is raised in the following cycle, whatever `cs_n` and `dir_wr` do in that cycle.
- R6: When `mbx_sel` is 1 at an edge, neither strobe is raised in the following cycle, and `push_data` keeps its value.
- R7: `room_ok`=0 blocks a write and `data_ok`=0 blocks a read. Each flag affects only its own operation.
- R8: When `cs_n` is 1 at an edge, neither strobe is raised in the following cycle.
- R9: `push_stb` and `pop_stb` are never 1 in the same cycle.
- R10: `push_data` takes the value of `bus_in` at each edge that accepts a write (R3) and holds its value at every other edge outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| dir_wr | input | 1 | Direction select: 1 = write into inbound FIFO, 0 = read from outbound FIFO |
| op_en | input | 1 | Operation enable, active high |
| mbx_sel | input | 1 | Mailbox select; 1 diverts the access away from the FIFOs |
| room_ok | input | 1 | Inbound FIFO can accept a word (not full) |
| data_ok | input | 1 | Outbound FIFO has a word to read (not empty) |
| bus_in | input | DATA_W | Word sampled from the shared data bus |
| bus_oe | output | 1 | Drive enable for the bus's tri-state output buffers |
| push_stb | output | 1 | One-cycle write strobe to the inbound FIFO |
| push_data | output | DATA_W | Registered word that goes with `push_stb` |
| pop_stb | output | 1 | One-cycle read strobe to the outbound FIFO |

## Verification
The bench first covers each case where one qualifier alone blocks an operation: enable low, mailbox high, chip select high, and the flag for that direction low. A decoder that leaves a term out would then issue a strobe that overflows a full FIFO or reads from an empty one. Other directed cases hold chip select and direction at values that drive the bus while enable is low, toggle the direction during reset, and change the data on a blocked write. These would expose an output-enable that waits for the clock, one that is gated by reset, or a data register that captures without a write. Random cycles hit back-to-back writes and reads and immediate changes of direction. There a design that stretches pulses or swaps which flag goes with which direction would be caught.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_PUSH  = 2'd1,
        ACC_POP   = 2'd2
    } access_e;

    typedef struct packed {
        logic cs_n;
        logic dir_wr;
        logic op_en;
        logic mbx_sel;
        logic room_ok;
        logic data_ok;
    } port_ctl_t;

    // Classify one cycle's control pins into a FIFO access.
    function automatic access_e classify(input port_ctl_t c);
        access_e kind;
        kind = ACC_NONE;
        if (!c.cs_n && c.op_en && !c.mbx_sel) begin
            if (c.dir_wr && c.room_ok)
                kind = ACC_PUSH;
            else if (!c.dir_wr && c.data_ok)
                kind = ACC_POP;
        end
        return kind;
    endfunction

    // Bus is driven only for a selected read-direction port.
    function automatic logic drive_bus(input logic cs_n, input logic dir_wr);
        return !cs_n && !dir_wr;
    endfunction

endpackage

// File: rtl/fpa_bus_dir.sv
module fpa_bus_dir (
    input  logic cs_n,
    input  logic dir_wr,
    output logic oe
);
    import fifo_port_pkg::*;

    always_comb oe = drive_bus(cs_n, dir_wr);

    // R1: a write-direction or deselected port never drives the bus
    always_comb begin
        if (cs_n || dir_wr)
            a_r1_no_drive_off: assert (oe == 1'b0);
    end
endmodule

// File: rtl/fpa_access_decode.sv
module fpa_access_decode (
    input  fifo_port_pkg::port_ctl_t ctl,
    output fifo_port_pkg::access_e   kind
);
    import fifo_port_pkg::*;

    always_comb kind = classify(ctl);

    // R5, R6, R8: any single blocking qualifier forces no access
    always_comb begin
        if (!ctl.op_en || ctl.mbx_sel || ctl.cs_n)
            a_r5_blocked_idle: assert (kind == ACC_NONE);
    end

    // R7: flags gate only their own direction
    always_comb begin
        if (kind == ACC_PUSH)
            a_r7_push_has_room: assert (ctl.room_ok && ctl.dir_wr);
        if (kind == ACC_POP)
            a_r7_pop_has_data: assert (ctl.data_ok && !ctl.dir_wr);
    end
endmodule

// File: rtl/fpa_strobe_reg.sv
module fpa_strobe_reg #(
    parameter int DATA_W = 36
) (
    input  logic                     clk,
    input  logic                     rst,
    input  fifo_port_pkg::access_e   kind,
    input  logic [DATA_W-1:0]        bus_in,
    output logic                     push_stb,
    output logic                     pop_stb,
    output logic [DATA_W-1:0]        push_data
);
    import fifo_port_pkg::*;

    logic take_push;
    logic take_pop;

    always_comb begin
        take_push = (kind == ACC_PUSH);
        take_pop  = (kind == ACC_POP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_stb  <= 1'b0;
            pop_stb   <= 1'b0;
            push_data <= '0;
        end else begin
            push_stb <= take_push;
            pop_stb  <= take_pop;
            if (take_push)
                push_data <= bus_in;
        end
    end

    // R9: strobes are mutually exclusive
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(push_stb && pop_stb));

    // R3: a write strobe is always caused by an accepted write
    a_r3_push_cause: assert property (@(posedge clk) disable iff (rst)
        push_stb |-> $past(take_push));

    // R4: a read strobe is always caused by an accepted read
    a_r4_pop_cause: assert property (@(posedge clk) disable iff (rst)
        pop_stb |-> $past(take_pop));

    // R10: captured word stays put unless a write was accepted
    a_r10_data_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(take_push)) |-> $stable(push_data));

    // R2: reset leaves both strobes idle
    a_r2_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!push_stb && !pop_stb));
endmodule

// File: rtl/fifo_port_access.sv
module fifo_port_access #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              dir_wr,
    input  logic              op_en,
    input  logic              mbx_sel,
    input  logic              room_ok,
    input  logic              data_ok,
    input  logic [DATA_W-1:0] bus_in,
    output logic              bus_oe,
    output logic              push_stb,
    output logic [DATA_W-1:0] push_data,
    output logic              pop_stb
);
    import fifo_port_pkg::*;

    port_ctl_t ctl;
    access_e   kind;

    always_comb begin
        ctl.cs_n    = cs_n;
        ctl.dir_wr  = dir_wr;
        ctl.op_en   = op_en;
        ctl.mbx_sel = mbx_sel;
        ctl.room_ok = room_ok;
        ctl.data_ok = data_ok;
    end

    fpa_bus_dir u_dir (
        .cs_n   (cs_n),
        .dir_wr (dir_wr),
        .oe     (bus_oe)
    );

    fpa_access_decode u_dec (
        .ctl  (ctl),
        .kind (kind)
    );

    fpa_strobe_reg #(.DATA_W(DATA_W)) u_stb (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .bus_in    (bus_in),
        .push_stb  (push_stb),
        .pop_stb   (pop_stb),
        .push_data (push_data)
    );

    // R6: a mailbox access leaves the FIFO strobes idle next cycle
    a_r6_mbx_no_strobe: assert property (@(posedge clk) disable iff (rst)
        mbx_sel |=> (!push_stb && !pop_stb));

    // R8: a deselected port issues no strobe next cycle
    a_r8_desel_no_strobe: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!push_stb && !pop_stb));
endmodule

// File: tb/fifo_port_access_tb_top.sv
module fifo_port_access_tb_top;
    localparam int DATA_W = 36;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1;
    logic              dir_wr = 1'b0;
    logic              op_en = 1'b0;
    logic              mbx_sel = 1'b0;
    logic              room_ok = 1'b0;
    logic              data_ok = 1'b0;
    logic [DATA_W-1:0] bus_in = '0;
    logic              bus_oe;
    logic              push_stb;
    logic [DATA_W-1:0] push_data;
    logic              pop_stb;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] exp_data = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_port_access #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .dir_wr(dir_wr), .op_en(op_en),
        .mbx_sel(mbx_sel), .room_ok(room_ok), .data_ok(data_ok),
        .bus_in(bus_in), .bus_oe(bus_oe), .push_stb(push_stb),
        .push_data(push_data), .pop_stb(pop_stb)
    );

    function automatic logic exp_oe(input logic c, input logic d);
        return (c == 1'b0) && (d == 1'b0);
    endfunction

    function automatic logic exp_push(input logic r, input logic c, input logic d,
                                      input logic e, input logic m, input logic ro);
        return !r && !c && d && e && !m && ro;
    endfunction

    function automatic logic exp_pop(input logic r, input logic c, input logic d,
                                     input logic e, input logic m, input logic dk);
        return !r && !c && !d && e && !m && dk;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the bus enable straight away,
    // then check strobes and data just after the next rising edge.
    task automatic cycle(input logic r, input logic c, input logic d, input logic e,
                         input logic m, input logic ro, input logic dk,
                         input logic [DATA_W-1:0] w, input string req);
        logic ep, eo;
        @(negedge clk);
        rst = r; cs_n = c; dir_wr = d; op_en = e; mbx_sel = m;
        room_ok = ro; data_ok = dk; bus_in = w;
        #1;
        check({"R1 bus_oe ", req}, 64'(bus_oe), 64'(exp_oe(c, d)));
        ep = exp_push(r, c, d, e, m, ro);
        eo = exp_pop(r, c, d, e, m, dk);
        if (r) exp_data = '0;
        else if (ep) exp_data = w;
        @(posedge clk);
        #1;
        check({"R3 push_stb ", req}, 64'(push_stb), 64'(ep));
        check({"R4 pop_stb ", req}, 64'(pop_stb), 64'(eo));
        check({"R10 push_data ", req}, 64'(push_data), 64'(exp_data));
        check({"R9 exclusive ", req}, 64'(push_stb & pop_stb), 64'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_1234);
        // R2: reset holds strobes low even with write/read conditions present
        cycle(1, 0, 1, 1, 0, 1, 1, 36'h123456789, "R2 reset write");
        cycle(1, 0, 0, 1, 0, 1, 1, 36'h0AAAA5555, "R2 reset read");
        // R1: bus drive during reset follows pins alone
        @(negedge clk); rst = 1; cs_n = 0; dir_wr = 0; #1;
        check("R1 oe during reset", 64'(bus_oe), 64'd1);
        dir_wr = 1; #1;
        check("R1 oe off during reset", 64'(bus_oe), 64'd0);
        cycle(0, 1, 0, 0, 0, 0, 0, '0, "R2 leave reset");
        // R3 basic write, R10 capture
        cycle(0, 0, 1, 1, 0, 1, 0, 36'hFEDCBA987, "R3 write");
        // R7 full blocks write, data held
        cycle(0, 0, 1, 1, 0, 0, 1, 36'h111111111, "R7 full blocks");
        // R6 mailbox blocks write and data held
        cycle(0, 0, 1, 1, 1, 1, 1, 36'h222222222, "R6 mbx write");
        cycle(0, 0, 0, 1, 1, 1, 1, 36'h333333333, "R6 mbx read");
        // R4 read; R7 empty blocks read
        cycle(0, 0, 0, 1, 0, 0, 1, 36'h444444444, "R4 read");
        cycle(0, 0, 0, 1, 0, 1, 0, 36'h555555555, "R7 empty blocks");
        // R5 enable low with pins toggling mid-cycle
        cycle(0, 0, 0, 0, 0, 1, 1, 36'h666666666, "R5 en low read");
        @(negedge clk); dir_wr = 1; #1;
        check("R1 oe async on dir change", 64'(bus_oe), 64'd0);
        cs_n = 1; #1;
        check("R1 oe async on cs change", 64'(bus_oe), 64'd0);
        cycle(0, 0, 1, 0, 0, 1, 1, 36'h777777777, "R5 en low write");
        // R8 deselected
        cycle(0, 1, 1, 1, 0, 1, 1, 36'h888888888, "R8 cs high write");
        cycle(0, 1, 0, 1, 0, 1, 1, 36'h999999999, "R8 cs high read");
        // back-to-back writes and turnaround
        cycle(0, 0, 1, 1, 0, 1, 1, 36'h0000000A1, "R3 b2b write 1");
        cycle(0, 0, 1, 1, 0, 1, 1, 36'h0000000A2, "R3 b2b write 2");
        cycle(0, 0, 0, 1, 0, 1, 1, 36'h0000000A3, "R4 turnaround read");
        cycle(0, 0, 1, 1, 0, 1, 1, 36'h0000000A4, "R3 turnaround write");
        cycle(0, 1, 0, 0, 0, 0, 0, '0, "R3 idle after");
        // constrained random: enable and select mostly active
        for (int i = 0; i < 400; i++) begin
            logic [DATA_W-1:0] w;
            w = {$urandom(), $urandom()} & {DATA_W{1'b1}};
            cycle(($urandom() % 50) == 0,
                  ($urandom() % 4) == 0,
                  1'($urandom()),
                  ($urandom() % 4) != 0,
                  ($urandom() % 5) == 0,
                  ($urandom() % 3) != 0,
                  ($urandom() % 3) != 0,
                  w, "random");
        end
        if (seed == 0) $display("seed zero");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule